// File: doc/BRIEF.md
# Sequenced Chip Reset Controller

The block gathers every reset request of a small chip into one chip reset output and holds that output until the start-up timers have run out. The requests are:

- an asynchronous power-on request;
- a brown-out level;
- an external reset pin, which takes effect only while its enable input is high;
- single-cycle strobes for watchdog time-out, the reset instruction, stack overflow and stack underflow.

Two timers follow a power-on or brown-out event. The power-up timer counts ticks of a slow low-power clock. The oscillator start-up timer then counts main-oscillator cycles. Both clocks reach the block as single-cycle tick enables in the system clock domain.

An 8-bit status register records which reset happened. Each of its six cause flags is active-low. The flag for a cause is cleared by that cause, and software sets it again by writing a 1. The pattern of cleared flags therefore identifies the most recent reset. The register also holds two control bits: an interrupt-priority enable and a software brown-out enable.

The sequencer is a four-state machine. `ST_HOLD` is held while any reset source is active. `ST_PWRT` counts slow ticks and `ST_OST` counts oscillator ticks. `ST_RUN` is the only state in which the chip reset is released. The transitions are:

- any state to `ST_HOLD` when a source is active;
- `ST_HOLD` to `ST_PWRT` when the power-up timer is enabled and not yet expired;
- `ST_HOLD` or `ST_PWRT` to `ST_OST` when the oscillator timer is enabled and not yet expired;
- `ST_HOLD`, `ST_PWRT` or `ST_OST` to `ST_RUN` when no enabled timer remains.

Top module: `rst_sequencer`

## Requirements
- R1: While `por_req` is high, `chip_rst` is 1 and `status` reads 8'h67. In that value, the power-on flag (bit 3) and the brown-out flag (bit 4) are 0, the other cause flags are 1, bit 6 is 1 and bit 7 is 0. Both timers are also cleared.
- R2: After power-on with both timers enabled, `chip_rst` stays 1 until the power-up timer has counted 2^PWRT_W `lf_tick` pulses and then the oscillator timer has counted 2^OST_W `osc_tick` pulses. `osc_tick` pulses that arrive during the power-up phase are not counted.
- R3: A `wdt_to`, `ri_strobe`, `stk_full` or `stk_under` pulse one cycle long, arriving after both timers have expired, gives `chip_rst`=1 for exactly one cycle after the edge that samples it. No timer is rerun.
- R4: When `mclr_en`=1, a low level on `mclr_n` passes through a 2-flop synchronizer. `chip_rst` rises on the third clock edge and stays high while the pin is low. When `mclr_en`=0, the pin has no effect.
- R5: `bor_mode` selects the brown-out response: 2'b00 ignores `bor_req`, 2'b01 lets it act only while `status[6]` is 1, and 2'b1x always lets it act. An active brown-out clears `status[4]` and restarts both timers.
- R6: The cause flags are active-low and are cleared by their own event. The positions are: bit 0 reset instruction, bit 1 watchdog, bit 2 pin reset while `pm_mode`=1, bit 3 power-on, bit 4 brown-out, bit 5 stack overflow or underflow. A pin reset with `pm_mode`=0 changes no flag.
- R7: A write (`sw_we`=1) sets each flag in bits 5..0 where `sw_wdata` has a 1 and ignores the 0s. It loads bits 6 and 7 directly.
- R8: When several events arrive in the same cycle, only the winner's flag is cleared. The order is power-on, then brown-out, watchdog, reset instruction, stack fault, power-managed pin. An event's clear overrides a write to the same bit.
- R9: With `pwrt_en`=0 the power-up phase is skipped. With `ost_en`=0 the oscillator phase is skipped.
- R10: `chip_rst` is 1 in every cycle that follows a cycle with an active reset source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_req | input | 1 | Power-on request, asynchronous, active high |
| mclr_n | input | 1 | External reset pin, active low |
| mclr_en | input | 1 | Enables the external pin reset |
| pm_mode | input | 1 | Chip is in a power-managed mode |
| bor_req | input | 1 | Brown-out level, asynchronous |
| bor_mode | input | 2 | Brown-out response configuration |
| wdt_to | input | 1 | Watchdog time-out strobe |
| ri_strobe | input | 1 | Reset instruction strobe |
| stk_full | input | 1 | Stack overflow strobe |
| stk_under | input | 1 | Stack underflow strobe |
| lf_tick | input | 1 | One pulse per slow-clock period |
| osc_tick | input | 1 | One pulse per main-oscillator cycle |
| pwrt_en | input | 1 | Enables the power-up timer |
| ost_en | input | 1 | Enables the oscillator start-up timer |
| sw_we | input | 1 | Status register write strobe |
| sw_wdata | input | 8 | Status register write data |
| status | output | 8 | Reset cause flags and control bits |
| chip_rst | output | 1 | Chip reset, active high |

## Verification
Most internal faults show up directly as a change in the timing of `chip_rst`. If the state register or a timer's done flag is corrupted, `chip_rst` drops several ticks early or late: the bench counts the exact number of ticks before release. A fault in the priority logic or the flag update shows up in `status` on the edge after the strobe, one cycle after the event. A synchronizer with the wrong depth moves the rising edge of `chip_rst` by one cycle from its third-edge position.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_PWRT = 2'd1,
        ST_OST  = 2'd2,
        ST_RUN  = 2'd3
    } seq_state_t;

    localparam int STAT_W   = 8;
    localparam int F_RI     = 0;
    localparam int F_WDT    = 1;
    localparam int F_PMPIN  = 2;
    localparam int F_POR    = 3;
    localparam int F_BOR    = 4;
    localparam int F_STK    = 5;
    localparam int B_SBOREN = 6;
    localparam int B_IPEN   = 7;

    localparam logic [STAT_W-1:0] STAT_POR_VAL = 8'h67;

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         por,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [N-1:0] stg [STAGES];

    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/rst_timer.sv
module rst_timer #(
    parameter int W = 10
) (
    input  logic clk,
    input  logic por,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam logic [W-1:0] LAST = '1;

    logic [W-1:0] cnt;

    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (clr) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (run && tick && !done) begin
            if (cnt == LAST) begin
                done <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rst_cause.sv
module rst_cause
    import rst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              por,
    input  logic              bor_evt,
    input  logic              wdt_evt,
    input  logic              ri_evt,
    input  logic              stk_evt,
    input  logic              pmpin_evt,
    input  logic              we,
    input  logic [STAT_W-1:0] wdata,
    output logic [STAT_W-1:0] status
);
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] stat_d;

    always_comb begin
        stat_d = stat_q;
        if (we) begin
            stat_d[F_STK:0]  = stat_q[F_STK:0] | wdata[F_STK:0];
            stat_d[B_SBOREN] = wdata[B_SBOREN];
            stat_d[B_IPEN]   = wdata[B_IPEN];
        end
        if (bor_evt)        stat_d[F_BOR]   = 1'b0;
        else if (wdt_evt)   stat_d[F_WDT]   = 1'b0;
        else if (ri_evt)    stat_d[F_RI]    = 1'b0;
        else if (stk_evt)   stat_d[F_STK]   = 1'b0;
        else if (pmpin_evt) stat_d[F_PMPIN] = 1'b0;
    end

    always_ff @(posedge clk or posedge por) begin
        if (por) stat_q <= STAT_POR_VAL;
        else     stat_q <= stat_d;
    end

    assign status = stat_q;
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
    import rst_seq_pkg::*;
#(
    parameter int PWRT_W = 11,
    parameter int OST_W  = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        por_req,
    input  logic        mclr_n,
    input  logic        mclr_en,
    input  logic        pm_mode,
    input  logic        bor_req,
    input  logic [1:0]  bor_mode,
    input  logic        wdt_to,
    input  logic        ri_strobe,
    input  logic        stk_full,
    input  logic        stk_under,
    input  logic        lf_tick,
    input  logic        osc_tick,
    input  logic        pwrt_en,
    input  logic        ost_en,
    input  logic        sw_we,
    input  logic [7:0]  sw_wdata,
    output logic [7:0]  status,
    output logic        chip_rst
);
    localparam int NSYNC = 2;

    seq_state_t state, state_nxt;
    logic [NSYNC-1:0] async_raw, async_s;
    logic pin_s, bor_s;
    logic pin_act, pmpin_evt, bor_eff, stk_evt, src_any;
    logic pwrt_done, ost_done;
    logic pwrt_left, ost_left;

    assign async_raw = {bor_req, ~mclr_n};

    rst_sync #(.N(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .por (por_req),
        .din (async_raw),
        .dout(async_s)
    );

    assign pin_s = async_s[0];
    assign bor_s = async_s[1];

    assign pin_act   = mclr_en && pin_s;
    assign pmpin_evt = pin_act && pm_mode;
    assign bor_eff   = bor_s && (bor_mode[1] ||
                       (bor_mode == 2'b01 && status[B_SBOREN]));
    assign stk_evt   = stk_full || stk_under;
    assign src_any   = pin_act || bor_eff || wdt_to || ri_strobe || stk_evt;

    rst_cause u_cause (
        .clk      (clk),
        .por      (por_req),
        .bor_evt  (bor_eff),
        .wdt_evt  (wdt_to),
        .ri_evt   (ri_strobe),
        .stk_evt  (stk_evt),
        .pmpin_evt(pmpin_evt),
        .we       (sw_we),
        .wdata    (sw_wdata),
        .status   (status)
    );

    rst_timer #(.W(PWRT_W)) u_pwrt (
        .clk (clk),
        .por (por_req),
        .clr (bor_eff),
        .run (state == ST_PWRT),
        .tick(lf_tick),
        .done(pwrt_done)
    );

    rst_timer #(.W(OST_W)) u_ost (
        .clk (clk),
        .por (por_req),
        .clr (bor_eff),
        .run (state == ST_OST),
        .tick(osc_tick),
        .done(ost_done)
    );

    assign pwrt_left = pwrt_en && !pwrt_done;
    assign ost_left  = ost_en && !ost_done;

    always_ff @(posedge clk or posedge por_req) begin
        if (por_req) state <= ST_HOLD;
        else         state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HOLD: begin
                if (src_any)        state_nxt = ST_HOLD;
                else if (pwrt_left) state_nxt = ST_PWRT;
                else if (ost_left)  state_nxt = ST_OST;
                else                state_nxt = ST_RUN;
            end
            ST_PWRT: begin
                if (src_any)        state_nxt = ST_HOLD;
                else if (pwrt_left) state_nxt = ST_PWRT;
                else if (ost_left)  state_nxt = ST_OST;
                else                state_nxt = ST_RUN;
            end
            ST_OST: begin
                if (src_any)        state_nxt = ST_HOLD;
                else if (ost_left)  state_nxt = ST_OST;
                else                state_nxt = ST_RUN;
            end
            ST_RUN: begin
                if (src_any)        state_nxt = ST_HOLD;
                else                state_nxt = ST_RUN;
            end
            default:                state_nxt = ST_HOLD;
        endcase
    end

    always_comb begin
        chip_rst = (state != ST_RUN);
    end
endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk (
    input logic clk,
    input logic por_req,
    input logic wdt_to,
    input logic ri_strobe,
    input logic stk_full,
    input logic stk_under,
    input logic chip_rst,
    input logic wd_flag,
    input logic pwrt_en,
    input logic ost_en,
    input logic pwrt_done,
    input logic ost_done,
    input logic bor_eff,
    input logic src_any
);
    // R3: any strobe forces chip reset in the next cycle
    p_strobe_hold_r3: assert property (@(posedge clk) disable iff (por_req)
        (wdt_to || ri_strobe || stk_full || stk_under) |=> chip_rst);

    // R10: an active source is always followed by chip reset
    p_src_hold_r10: assert property (@(posedge clk) disable iff (por_req)
        src_any |=> chip_rst);

    // R2: release only once every enabled timer has expired
    p_release_timers_r2: assert property (@(posedge clk) disable iff (por_req)
        $fell(chip_rst) |-> ((!$past(pwrt_en) || $past(pwrt_done)) &&
                             (!$past(ost_en) || $past(ost_done))));

    // R5: brown-out restarts both timers
    p_bor_restart_r5: assert property (@(posedge clk) disable iff (por_req)
        bor_eff |=> (!pwrt_done && !ost_done));

    // R8: watchdog clears its flag unless brown-out wins
    p_wdt_flag_r8: assert property (@(posedge clk) disable iff (por_req)
        (wdt_to && !bor_eff) |=> !wd_flag);

    // R6: watchdog flag only falls because of a watchdog event
    p_wdt_cause_r6: assert property (@(posedge clk) disable iff (por_req)
        $fell(wd_flag) |-> $past(wdt_to));
endmodule

bind rst_sequencer rst_sequencer_chk u_chk (
    .clk      (clk),
    .por_req  (por_req),
    .wdt_to   (wdt_to),
    .ri_strobe(ri_strobe),
    .stk_full (stk_full),
    .stk_under(stk_under),
    .chip_rst (chip_rst),
    .wd_flag  (status[1]),
    .pwrt_en  (pwrt_en),
    .ost_en   (ost_en),
    .pwrt_done(pwrt_done),
    .ost_done (ost_done),
    .bor_eff  (bor_eff),
    .src_any  (src_any)
);

// File: tb/sim_rst_sequencer.sv
module sim_rst_sequencer;
    logic clk = 1'b0;
    logic por_req = 1'b1, mclr_n = 1'b1, mclr_en = 1'b0, pm_mode = 1'b0;
    logic bor_req = 1'b0;
    logic [1:0] bor_mode = 2'b00;
    logic wdt_to = 1'b0, ri_strobe = 1'b0, stk_full = 1'b0, stk_under = 1'b0;
    logic lf_tick = 1'b0, osc_tick = 1'b0, pwrt_en = 1'b1, ost_en = 1'b1;
    logic sw_we = 1'b0;
    logic [7:0] sw_wdata = 8'h00;
    logic [7:0] status;
    logic chip_rst;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rst_sequencer #(.PWRT_W(3), .OST_W(2)) u0 (
        .clk(clk), .por_req(por_req), .mclr_n(mclr_n), .mclr_en(mclr_en),
        .pm_mode(pm_mode), .bor_req(bor_req), .bor_mode(bor_mode),
        .wdt_to(wdt_to), .ri_strobe(ri_strobe), .stk_full(stk_full),
        .stk_under(stk_under), .lf_tick(lf_tick), .osc_tick(osc_tick),
        .pwrt_en(pwrt_en), .ost_en(ost_en), .sw_we(sw_we),
        .sw_wdata(sw_wdata), .status(status), .chip_rst(chip_rst)
    );

    // [12] chip_rst, [11:4] status, [3:0] {stk_under, stk_full, ri, wdt}
    localparam logic [12:0] VEC [9] = '{
        {1'b1, 8'h7D, 4'b0001},
        {1'b1, 8'h7E, 4'b0010},
        {1'b1, 8'h5F, 4'b0100},
        {1'b1, 8'h5F, 4'b1000},
        {1'b1, 8'h7D, 4'b0011},
        {1'b1, 8'h7E, 4'b1010},
        {1'b1, 8'h5F, 4'b1100},
        {1'b1, 8'h7D, 4'b0101},
        {1'b0, 8'h7F, 4'b0000}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic lf(input int n);
        lf_tick = 1'b1; cyc(n); lf_tick = 1'b0;
    endtask

    task automatic osc(input int n);
        osc_tick = 1'b1; cyc(n); osc_tick = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        sw_we = 1'b1; sw_wdata = d; cyc(1); sw_we = 1'b0;
    endtask

    task automatic run_timers();
        lf(8); cyc(2); osc(4); cyc(3);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        cyc(2);
        chk("R1 status", status, 8'h67);
        chk("R1 chip_rst", {7'b0, chip_rst}, 8'h01);
        por_req = 1'b0;
        cyc(2);
        osc(10);
        chk("R2 osc ignored in power-up", {7'b0, chip_rst}, 8'h01);
        lf(7); cyc(1);
        chk("R2 one tick short", {7'b0, chip_rst}, 8'h01);
        lf(1); cyc(2); osc(3);
        chk("R2 osc one short", {7'b0, chip_rst}, 8'h01);
        osc(1); cyc(3);
        chk("R2 released", {7'b0, chip_rst}, 8'h00);

        wr(8'h7F);
        chk("R7 write sets", status, 8'h7F);
        wr(8'h00);
        chk("R7 zeros ignored", status, 8'h3F);

        for (int i = 0; i < 9; i++) begin
            wr(8'h7F);
            {stk_under, stk_full, ri_strobe, wdt_to} = VEC[i][3:0];
            cyc(1);
            {stk_under, stk_full, ri_strobe, wdt_to} = 4'b0000;
            chk("R6/R8 vec status", status, VEC[i][11:4]);
            chk("R3 vec rst", {7'b0, chip_rst}, {7'b0, VEC[i][12]});
            cyc(1);
            chk("R3 one cycle only", {7'b0, chip_rst}, 8'h00);
        end

        sw_we = 1'b1; sw_wdata = 8'h7F; wdt_to = 1'b1;
        cyc(1);
        sw_we = 1'b0; wdt_to = 1'b0;
        chk("R8 event beats write", status, 8'h7D);
        wr(8'h7F); cyc(1);

        mclr_en = 1'b1; mclr_n = 1'b0;
        cyc(2);
        chk("R4 not yet", {7'b0, chip_rst}, 8'h00);
        cyc(1);
        chk("R4 third edge", {7'b0, chip_rst}, 8'h01);
        cyc(4);
        chk("R10 held while low", {7'b0, chip_rst}, 8'h01);
        chk("R6 normal pin no flag", status, 8'h7F);
        pm_mode = 1'b1; cyc(1);
        chk("R6 pm pin flag", status, 8'h7B);
        mclr_n = 1'b1; pm_mode = 1'b0;
        cyc(3);
        chk("R4 pin released", {7'b0, chip_rst}, 8'h00);
        mclr_en = 1'b0; mclr_n = 1'b0;
        cyc(6);
        chk("R4 disabled pin", {7'b0, chip_rst}, 8'h00);
        mclr_n = 1'b1; cyc(3);

        bor_req = 1'b1; cyc(5);
        chk("R5 mode off rst", {7'b0, chip_rst}, 8'h00);
        chk("R5 mode off flag", status, 8'h7B);
        bor_req = 1'b0; bor_mode = 2'b01; cyc(3);
        bor_req = 1'b1; cyc(4);
        chk("R5 sw enabled rst", {7'b0, chip_rst}, 8'h01);
        chk("R5 bor flag", status, 8'h6B);
        bor_req = 1'b0; cyc(6);
        chk("R5 timers rerun", {7'b0, chip_rst}, 8'h01);
        run_timers();
        chk("R5 released after timers", {7'b0, chip_rst}, 8'h00);

        wr(8'h3F);
        chk("R7 sboren cleared", status, 8'h3F);
        bor_req = 1'b1; cyc(5);
        chk("R5 sw disabled", {7'b0, chip_rst}, 8'h00);
        bor_req = 1'b0; cyc(3);

        wr(8'h7F);
        bor_mode = 2'b10; bor_req = 1'b1; cyc(4);
        wdt_to = 1'b1; cyc(1); wdt_to = 1'b0;
        chk("R8 bor beats wdt", status, 8'h6F);
        pwrt_en = 1'b0; bor_req = 1'b0; cyc(4);
        chk("R9 waits for osc", {7'b0, chip_rst}, 8'h01);
        osc(4); cyc(3);
        chk("R9 power-up skipped", {7'b0, chip_rst}, 8'h00);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=done");
            summary();
            $finish;
        end
    end
endmodule